// File: doc/BRIEF.md
# Jump-Class Branch Resolver for a 64-bit Packet-Filter Instruction Set

This block settles the outcome of one jump-class instruction of a 64-bit in-kernel packet-filter instruction set. It receives the opcode byte, the source-register field, the 16-bit branch displacement, the 32-bit immediate, both operand values, the current program counter and a strobe. One clock later it reports four things: whether the branch is taken, the program counter to fetch next, whether the instruction is a call or a program return, and whether the encoding is illegal.

Two jump classes exist. The wide class compares all 64 operand bits. The narrow class compares only the low 32 bits. The program counter counts 8-byte instruction slots. The narrow class has one unconditional jump, selected by a source field of 1, and it takes its displacement from the 32-bit immediate. This gives a reach far beyond the 16-bit displacement that every other jump uses. The decoder enforces the legality rules of each class. It does not fetch instructions, read registers or carry out calls.

Top module: `jump_resolver`

## Requirements
- R1: All outputs are registered. The values driven one cycle after a cycle with `in_valid` high describe the instruction presented in that cycle, and `out_valid` is 1. After a cycle with `in_valid` low, and after reset, `out_valid`, `out_taken`, `out_call`, `out_exit` and `out_illegal` are 0 and `out_next_pc` is 0.
- R2: Opcode bits 2:0 give the class. 3'b101 is the wide (64-bit) jump class and 3'b110 is the narrow (32-bit) jump class. For any other class value the result has `out_taken`, `out_call`, `out_exit` and `out_illegal` all 0 and `out_next_pc` = PC+1.
- R3: Opcode bit 3 picks the second operand of a compare. When the bit is 0, the second operand is the 32-bit immediate sign-extended to 64 bits. When the bit is 1, it is `in_src`. `in_dst` is always the first operand.
- R4: Opcode bits 7:4 hold the operation. Code 0x1 is taken when the operands are equal, code 0x5 when they differ, and code 0x4 when their bitwise AND is nonzero.
- R5: Unsigned orderings: code 0x2 is taken when dst > src, 0x3 when dst >= src, 0xa when dst < src and 0xb when dst <= src.
- R6: Signed two's-complement orderings: code 0x6 is taken when dst > src, 0x7 when dst >= src, 0xc when dst < src and 0xd when dst <= src.
- R7: In the narrow class only bits 31:0 of both operands take part in a compare, and bit 31 is the sign for codes 0x6, 0x7, 0xc and 0xd. Bits 63:32 have no effect there.
- R8: A taken conditional jump gives `out_next_pc` = PC + 1 + sign-extended 16-bit displacement, wrapping modulo 2^PC_W. A jump that is not taken gives PC+1.
- R9: Code 0x0 in the wide class is always taken with the 16-bit displacement, whatever the source field holds.
- R10: Code 0x0 in the narrow class with source field 1 is always taken, and `out_next_pc` = PC + 1 + sign-extended 32-bit immediate. With any other source field it is illegal.
- R11: In the wide class, code 0x8 sets `out_call` and code 0x9 sets `out_exit`. Both are not taken and both give `out_next_pc` = PC+1.
- R12: These encodings are illegal: codes 0xe and 0xf in either class, and codes 0x8 and 0x9 in the narrow class. An illegal instruction sets `out_illegal`, is never taken, leaves `out_call` and `out_exit` at 0, and gives `out_next_pc` = PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| in_opcode | input | 8 | Opcode byte: operation, operand select, class |
| in_srcfld | input | 4 | Source-register field of the instruction |
| in_off | input | 16 | Signed branch displacement |
| in_imm | input | 32 | Signed immediate |
| in_dst | input | 64 | First operand value |
| in_src | input | 64 | Source register value |
| in_pc | input | PC_W (32) | Slot index of the instruction |
| out_valid | output | 1 | A result is present |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | PC_W (32) | Next slot index |
| out_call | output | 1 | Call instruction |
| out_exit | output | 1 | Program return |
| out_illegal | output | 1 | Illegal encoding |

## Verification
The legality check and the condition-and-target path both act on every instruction in the same cycle. The bench provokes their overlap on purpose. It sends reserved codes and narrow-class calls and returns with operands that would satisfy a compare. It also sends narrow unconditional jumps with a wrong source field and a displacement that would move the PC. It accepts `out_illegal` high only together with `out_taken` low and `out_next_pc` = PC+1. In the same spirit, opcodes outside both jump classes whose high bits spell a jump code are checked to resolve as plain sequential instructions.

// File: rtl/jr_pkg.sv
package jr_pkg;

  typedef enum logic [3:0] {
    OP_JA   = 4'h0, OP_JEQ  = 4'h1, OP_JGT  = 4'h2, OP_JGE  = 4'h3,
    OP_JSET = 4'h4, OP_JNE  = 4'h5, OP_JSGT = 4'h6, OP_JSGE = 4'h7,
    OP_CALL = 4'h8, OP_EXIT = 4'h9, OP_JLT  = 4'ha, OP_JLE  = 4'hb,
    OP_JSLT = 4'hc, OP_JSLE = 4'hd, OP_RSVE = 4'he, OP_RSVF = 4'hf
  } jop_e;

  localparam logic [2:0] CLS_WIDE   = 3'b101;
  localparam logic [2:0] CLS_NARROW = 3'b110;

  // what the decoder asks the datapath to do
  typedef enum logic [2:0] {
    ACT_NONE, ACT_COND, ACT_JMP_OFF, ACT_JMP_IMM,
    ACT_CALL, ACT_EXIT, ACT_ILLEGAL
  } act_e;

  typedef struct packed {
    logic eq;   // a == b
    logic ult;  // a < b, unsigned
    logic slt;  // a < b, signed
    logic nz;   // (a & b) != 0
  } cmpf_t;

  function automatic logic cond_hit(input jop_e op, input cmpf_t f);
    logic r;
    case (op)
      OP_JEQ:  r = f.eq;
      OP_JNE:  r = !f.eq;
      OP_JSET: r = f.nz;
      OP_JGT:  r = !f.ult && !f.eq;
      OP_JGE:  r = !f.ult;
      OP_JLT:  r = f.ult;
      OP_JLE:  r = f.ult || f.eq;
      OP_JSGT: r = !f.slt && !f.eq;
      OP_JSGE: r = !f.slt;
      OP_JSLT: r = f.slt;
      OP_JSLE: r = f.slt || f.eq;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/jr_decode.sv
module jr_decode
  import jr_pkg::*;
#(
  parameter int SRCF_W = 4
) (
  input  logic [7:0]        opcode,
  input  logic [SRCF_W-1:0] srcfld,
  output act_e              act,
  output jop_e              op,
  output logic              narrow,
  output logic              use_reg
);
  logic [2:0] cls;
  logic       is_wide;

  assign cls     = opcode[2:0];
  assign op      = jop_e'(opcode[7:4]);
  assign use_reg = opcode[3];
  assign is_wide = (cls == CLS_WIDE);
  assign narrow  = (cls == CLS_NARROW);

  always_comb begin
    act = ACT_NONE;
    if (is_wide || narrow) begin
      case (op)
        OP_JA: begin
          if (is_wide)                                act = ACT_JMP_OFF;
          else if (srcfld == SRCF_W'(1))              act = ACT_JMP_IMM;
          else                                        act = ACT_ILLEGAL;
        end
        OP_CALL:          act = is_wide ? ACT_CALL : ACT_ILLEGAL;
        OP_EXIT:          act = is_wide ? ACT_EXIT : ACT_ILLEGAL;
        OP_RSVE, OP_RSVF: act = ACT_ILLEGAL;
        default:          act = ACT_COND;
      endcase
    end
  end
endmodule

// File: rtl/jr_cmp.sv
module jr_cmp
  import jr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmpf_t        flags
);
  always_comb begin
    flags.eq  = (a == b);
    flags.ult = (a < b);
    flags.slt = ($signed(a) < $signed(b));
    flags.nz  = |(a & b);
  end
endmodule

// File: rtl/jr_target.sv
module jr_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int IMM_W = 32
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic [IMM_W-1:0] imm,
  input  logic             sel_imm,
  output logic [PC_W-1:0]  pc_seq,
  output logic [PC_W-1:0]  pc_br
);
  function automatic logic [PC_W-1:0] sx_off(input logic [OFF_W-1:0] v);
    logic [PC_W+OFF_W-1:0] t;
    t = {{PC_W{v[OFF_W-1]}}, v};
    return t[PC_W-1:0];
  endfunction

  function automatic logic [PC_W-1:0] sx_imm(input logic [IMM_W-1:0] v);
    logic [PC_W+IMM_W-1:0] t;
    t = {{PC_W{v[IMM_W-1]}}, v};
    return t[PC_W-1:0];
  endfunction

  logic [PC_W-1:0] disp;

  assign pc_seq = pc + PC_W'(1);
  assign disp   = sel_imm ? sx_imm(imm) : sx_off(off);
  assign pc_br  = pc_seq + disp;
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jr_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int PC_W     = 32,
  parameter int OFF_W    = 16,
  parameter int IMM_W    = 32,
  parameter int SRCF_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic [SRCF_W-1:0] in_srcfld,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [PC_W-1:0]   in_pc,
  output logic              out_valid,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_call,
  output logic              out_exit,
  output logic              out_illegal
);
  localparam int IMM_PAD = DATA_W - IMM_W;

  act_e  dec_act;
  jop_e  dec_op;
  logic  dec_narrow;
  logic  dec_use_reg;

  jr_decode #(.SRCF_W(SRCF_W)) u_dec (
    .opcode (in_opcode),
    .srcfld (in_srcfld),
    .act    (dec_act),
    .op     (dec_op),
    .narrow (dec_narrow),
    .use_reg(dec_use_reg)
  );

  // second operand: register or sign-extended immediate
  logic [DATA_W-1:0] opnd_b;
  assign opnd_b = dec_use_reg ? in_src : {{IMM_PAD{in_imm[IMM_W-1]}}, in_imm};

  cmpf_t flags_wide, flags_narrow, flags_sel;

  jr_cmp #(.W(DATA_W)) u_cmp_wide (
    .a(in_dst), .b(opnd_b), .flags(flags_wide)
  );

  jr_cmp #(.W(NARROW_W)) u_cmp_narrow (
    .a(in_dst[NARROW_W-1:0]), .b(opnd_b[NARROW_W-1:0]), .flags(flags_narrow)
  );

  assign flags_sel = dec_narrow ? flags_narrow : flags_wide;

  // named events for the checker
  logic cond_true;
  logic br_take;
  logic dec_illegal;

  assign cond_true   = cond_hit(dec_op, flags_sel);
  assign dec_illegal = (dec_act == ACT_ILLEGAL);
  assign br_take     = ((dec_act == ACT_COND) && cond_true) ||
                       (dec_act == ACT_JMP_OFF) || (dec_act == ACT_JMP_IMM);

  logic [PC_W-1:0] pc_seq, pc_br;

  jr_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_tgt (
    .pc     (in_pc),
    .off    (in_off),
    .imm    (in_imm),
    .sel_imm(dec_act == ACT_JMP_IMM),
    .pc_seq (pc_seq),
    .pc_br  (pc_br)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !in_valid) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_next_pc <= '0;
      out_call    <= 1'b0;
      out_exit    <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= 1'b1;
      out_taken   <= br_take;
      out_next_pc <= br_take ? pc_br : pc_seq;
      out_call    <= (dec_act == ACT_CALL);
      out_exit    <= (dec_act == ACT_EXIT);
      out_illegal <= dec_illegal;
    end
  end
endmodule

// File: rtl/jump_resolver_chk.sv
module jump_resolver_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [7:0]      in_opcode,
  input logic [PC_W-1:0] in_pc,
  input logic            out_valid,
  input logic            out_taken,
  input logic [PC_W-1:0] out_next_pc,
  input logic            out_call,
  input logic            out_exit,
  input logic            out_illegal
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_taken && !out_call && !out_exit && !out_illegal && out_next_pc == '0)); // R1

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_taken, out_call, out_exit, out_illegal})); // R12

  AST_OTHER_CLASS_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opcode[2:0] != 3'b101 && in_opcode[2:0] != 3'b110)
      |=> (!out_taken && !out_illegal && !out_call && !out_exit)); // R2

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(in_opcode[2:0] inside {3'b101, 3'b110}))
      |=> out_next_pc == PC_W'(($past(in_pc)) + 1'b1)); // R8

  AST_WIDE_JA_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opcode[7:4] == 4'h0 && in_opcode[2:0] == 3'b101) |=> out_taken); // R9

  AST_RSV_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opcode[7:5] == 3'b111 && in_opcode[2:1] != 2'b00 &&
     in_opcode[2:0] inside {3'b101, 3'b110}) |=> out_illegal); // R12

  AST_NARROW_CALL_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opcode[7:5] == 3'b100 && in_opcode[2:0] == 3'b110) |=> out_illegal); // R12

  AST_WIDE_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opcode[7:4] == 4'h8 && in_opcode[2:0] == 3'b101)
      |=> (out_call && !out_taken)); // R11
endmodule

bind jump_resolver jump_resolver_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_opcode  (in_opcode),
  .in_pc      (in_pc),
  .out_valid  (out_valid),
  .out_taken  (out_taken),
  .out_next_pc(out_next_pc),
  .out_call   (out_call),
  .out_exit   (out_exit),
  .out_illegal(out_illegal)
);

// File: tb/jump_resolver_bench.sv
`timescale 1ns/1ps
module jump_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_opcode = '0;
  logic [3:0]  in_srcfld = '0;
  logic [15:0] in_off = '0;
  logic [31:0] in_imm = '0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic [31:0] in_pc = '0;
  logic        out_valid, out_taken, out_call, out_exit, out_illegal;
  logic [31:0] out_next_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  jump_resolver u_jump_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_srcfld(in_srcfld), .in_off(in_off), .in_imm(in_imm), .in_dst(in_dst),
    .in_src(in_src), .in_pc(in_pc), .out_valid(out_valid), .out_taken(out_taken),
    .out_next_pc(out_next_pc), .out_call(out_call), .out_exit(out_exit),
    .out_illegal(out_illegal)
  );

  // expected bundle: valid, taken, call, exit, illegal, next_pc
  typedef struct packed {
    logic v, t, c, e, i;
    logic [31:0] pc;
  } res_t;

  function automatic res_t model(bit v, logic [7:0] op, logic [3:0] sf, logic [15:0] off,
                                 logic [31:0] imm, logic [63:0] d, logic [63:0] s,
                                 logic [31:0] pc);
    res_t r;
    int unsigned code;
    bit wide, nar, hit;
    longint unsigned ua, ub;
    longint sa, sb, disp;
    logic [63:0] b;
    r = '0;
    if (!v) return r;
    r.v = 1;
    r.pc = pc + 32'd1;
    code = op[7:4];
    wide = (op[2:0] == 3'd5);
    nar  = (op[2:0] == 3'd6);
    if (!wide && !nar) return r;
    b = op[3] ? s : 64'($signed(imm));
    if (wide) begin ua = d; ub = b; sa = $signed(d); sb = $signed(b); end
    else begin
      ua = {32'd0, d[31:0]}; ub = {32'd0, b[31:0]};
      sa = longint'($signed(d[31:0])); sb = longint'($signed(b[31:0]));
    end
    hit = 0; disp = longint'($signed(off));
    if (code >= 14 || (nar && (code == 8 || code == 9)) || (nar && code == 0 && sf != 4'd1)) begin
      r.i = 1; return r;
    end
    case (code)
      0: begin hit = 1; if (nar) disp = longint'($signed(imm)); end
      1: hit = (ua == ub);
      2: hit = (ua > ub);
      3: hit = (ua >= ub);
      4: hit = ((ua & ub) != 0);
      5: hit = (ua != ub);
      6: hit = (sa > sb);
      7: hit = (sa >= sb);
      8: r.c = 1;
      9: r.e = 1;
      10: hit = (ua < ub);
      11: hit = (ua <= ub);
      12: hit = (sa < sb);
      13: hit = (sa <= sb);
      default: ;
    endcase
    r.t = hit;
    if (hit) r.pc = 32'(longint'(pc) + 1 + disp);
    return r;
  endfunction

  task automatic step(bit v, logic [7:0] op, logic [3:0] sf, logic [15:0] off,
                      logic [31:0] imm, logic [63:0] d, logic [63:0] s,
                      logic [31:0] pc, string tag);
    res_t exp, got;
    @(negedge clk);
    in_valid = v; in_opcode = op; in_srcfld = sf; in_off = off;
    in_imm = imm; in_dst = d; in_src = s; in_pc = pc;
    exp = model(v, op, sf, off, imm, d, s, pc);
    @(posedge clk); #1;
    got = '{out_valid, out_taken, out_call, out_exit, out_illegal, out_next_pc};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%02h: got v%0b t%0b c%0b e%0b i%0b pc=%08h, expected v%0b t%0b c%0b e%0b i%0b pc=%08h",
               tag, op, got.v, got.t, got.c, got.e, got.i, got.pc,
               exp.v, exp.t, exp.c, exp.e, exp.i, exp.pc);
    end
  endtask

  localparam logic [63:0] ONES = 64'hffff_ffff_ffff_ffff;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({out_valid, out_taken, out_call, out_exit, out_illegal, out_next_pc} !== '0) begin
      errors++;
      $display("FAIL R1 reset: got %b/%08h, expected all zero", {out_valid, out_taken, out_call, out_exit, out_illegal}, out_next_pc);
    end
    @(negedge clk); rst_n = 1;

    // R4 equality / set
    step(1, 8'h1d, 0, 16'd5, 0, 64'd7, 64'd7, 32'd100, "R4 jeq reg equal");
    step(1, 8'h1d, 0, 16'd5, 0, 64'd7, 64'd8, 32'd100, "R4 jeq reg differ");
    step(1, 8'h5d, 0, 16'd3, 0, 64'd7, 64'd8, 32'd20, "R4 jne");
    step(1, 8'h4d, 0, 16'd3, 0, 64'hf0, 64'h0f, 32'd20, "R4 jset zero");
    step(1, 8'h4d, 0, 16'd3, 0, 64'h1_0000_0000, 64'h1_0000_0000, 32'd20, "R4 jset high bit");
    // R3 immediate operand, sign-extended
    step(1, 8'h15, 0, 16'd9, 32'hffff_ffff, ONES, 64'd0, 32'd50, "R3 jeq imm sext");
    step(1, 8'h15, 0, 16'd9, 32'd4, 64'd4, 64'd99, 32'd50, "R3 src ignored in imm form");
    // R5 unsigned
    step(1, 8'h2d, 0, 16'd2, 0, ONES, 64'd1, 32'd8, "R5 jgt unsigned");
    step(1, 8'h3d, 0, 16'd2, 0, 64'd5, 64'd5, 32'd8, "R5 jge equal");
    step(1, 8'had, 0, 16'd2, 0, 64'd5, 64'd5, 32'd8, "R5 jlt equal");
    step(1, 8'hbd, 0, 16'd2, 0, 64'd5, 64'd5, 32'd8, "R5 jle equal");
    step(1, 8'had, 0, 16'd2, 0, 64'd1, ONES, 32'd8, "R5 jlt big");
    // R6 signed
    step(1, 8'h6d, 0, 16'd2, 0, ONES, 64'd1, 32'd8, "R6 jsgt neg");
    step(1, 8'h7d, 0, 16'd2, 0, 64'd1, ONES, 32'd8, "R6 jsge");
    step(1, 8'hcd, 0, 16'd2, 0, 64'h8000_0000_0000_0000, 64'd0, 32'd8, "R6 jslt min");
    step(1, 8'hdd, 0, 16'd2, 0, 64'd3, 64'd3, 32'd8, "R6 jsle equal");
    step(1, 8'h6d, 0, 16'd2, 0, 64'd3, 64'd3, 32'd8, "R6 jsgt equal");
    // R7 narrow class
    step(1, 8'h1e, 0, 16'd4, 0, 64'hdead_0000_0000_1234, 64'h0000_beef_0000_1234, 32'd30, "R7 narrow jeq low only");
    step(1, 8'h6e, 0, 16'd4, 0, 64'h0000_0000_8000_0000, 64'd1, 32'd30, "R7 narrow jsgt bit31 sign");
    step(1, 8'h2e, 0, 16'd4, 0, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001, 32'd30, "R7 narrow jgt");
    step(1, 8'h6d, 0, 16'd4, 0, 64'h0000_0000_8000_0000, 64'd1, 32'd30, "R7 wide contrast");
    // R8 displacement edges
    step(1, 8'h1d, 0, 16'hfffe, 0, 0, 0, 32'd10, "R8 negative offset");
    step(1, 8'h1d, 0, 16'h7fff, 0, 0, 0, 32'd10, "R8 max offset");
    step(1, 8'h1d, 0, 16'h8000, 0, 0, 0, 32'h0001_0000, "R8 min offset");
    step(1, 8'h1d, 0, 16'd1, 0, 0, 1, 32'hffff_ffff, "R8 not taken wraps");
    // R9 wide JA
    step(1, 8'h05, 4'd7, 16'hfff0, 32'd1234, 0, 0, 32'd200, "R9 wide ja any src");
    // R10 narrow JA
    step(1, 8'h06, 4'd1, 16'd3, 32'h7fff_ffff, 0, 0, 32'd5, "R10 narrow ja max");
    step(1, 8'h06, 4'd1, 16'd3, 32'h8000_0000, 0, 0, 32'd5, "R10 narrow ja min");
    step(1, 8'h06, 4'd0, 16'd3, 32'd100, 0, 0, 32'd5, "R10 narrow ja bad src");
    // R11 call / exit
    step(1, 8'h85, 0, 16'd3, 32'd1, 0, 0, 32'd77, "R11 call");
    step(1, 8'h95, 0, 16'd3, 0, 0, 0, 32'd77, "R11 exit");
    // R12 illegal overlaps
    step(1, 8'he5, 0, 16'd9, 0, 64'd1, 64'd1, 32'd40, "R12 code e");
    step(1, 8'hfe, 0, 16'd9, 0, 64'd1, 64'd1, 32'd40, "R12 code f narrow");
    step(1, 8'h86, 0, 16'd9, 0, 0, 0, 32'd40, "R12 narrow call");
    step(1, 8'h96, 0, 16'd9, 0, 0, 0, 32'd40, "R12 narrow exit");
    // R2 other classes
    step(1, 8'h07, 4'd1, 16'd9, 32'd9, 0, 0, 32'd60, "R2 class 7 ja bits");
    step(1, 8'h1c, 0, 16'd9, 0, 64'd1, 64'd1, 32'd60, "R2 class 4");
    // R1 idle after valid
    step(0, 8'h05, 0, 16'd9, 0, 0, 0, 32'd60, "R1 idle");
    step(1, 8'h05, 0, 16'd1, 0, 0, 0, 32'd60, "R1 resume");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [7:0] op;
      logic [63:0] d, s;
      op = 8'($urandom);
      if (k % 3 != 0) op[2:0] = (k % 2 == 0) ? 3'd5 : 3'd6;
      d = {$urandom, $urandom};
      s = (k % 4 == 0) ? d : {$urandom, $urandom};
      step((k % 7) != 3, op, 4'($urandom), 16'($urandom), $urandom, d, s, $urandom, "mixed");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule